// File: doc/BRIEF.md
# Servo Joint Command Parser

This block sits behind a byte-wide serial receiver and turns a stream of ASCII text into joint commands for a small servo arm. Each command is a line of exactly five bytes. The first byte is a joint letter. The next three bytes are a zero-padded decimal angle. The last byte is a newline (0x0A). The newline is the only framing mark. There is no length field and no checksum.

Bytes are offered one at a time with a qualifier, and any number of idle cycles may separate them. Parser state survives those gaps, so a line that arrives in pieces is still assembled. When a newline arrives, the block does one of two things:
- If the buffered line is well formed, it publishes the joint index and the angle with a one-cycle valid strobe.
- Otherwise it drops the line, raises a one-cycle error strobe and starts afresh with the next byte.

Top module: `servo_cmd_parser`

## Requirements
- R1: After reset, cmd_valid_o and cmd_err_o are 0, and cmd_joint_o and cmd_angle_o are 0.
- R2: A line of letter 'A', 'B' or 'C' (0x41..0x43), then three ASCII digits (0x30..0x39), then newline 0x0A raises cmd_valid_o for one cycle, in the cycle after the newline byte is taken. cmd_joint_o is 0, 1 or 2 for 'A', 'B' or 'C'. cmd_angle_o is the decimal value of the digits, with the first digit as hundreds.
- R3: A line that is otherwise well formed but whose decimal value exceeds 180 produces no valid strobe. Instead, cmd_err_o pulses for one cycle in the cycle after the newline.
- R4: A newline preceded by any count of bytes other than four (including zero, or more than four) discards the line with an error pulse and no valid strobe.
- R5: A first byte outside 'A'..'C' discards the line at its newline with an error pulse.
- R6: Any byte outside '0'..'9' in positions two to four discards the line at its newline with an error pulse.
- R7: Cycles with byte_valid_i low change no parser state. No strobe appears after a non-newline byte, and a line split by idle gaps is accepted as if it were contiguous.
- R8: After any discarded line, the next well-formed line is accepted normally.
- R9: cmd_valid_o and cmd_err_o are never high together. cmd_joint_o and cmd_angle_o change only together with a valid strobe and otherwise hold the last accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | byte_i carries a received byte this cycle |
| byte_i | input | 8 | Received byte |
| cmd_valid_o | output | 1 | One-cycle strobe: a command was accepted |
| cmd_joint_o | output | 2 | Joint index of the last accepted command |
| cmd_angle_o | output | 8 | Angle of the last accepted command |
| cmd_err_o | output | 1 | One-cycle strobe: a line was discarded |

## Verification
Every result of this block is registered once. The valid or error strobe, together with any new joint and angle, appears in the cycle after the rising edge that takes the newline. No strobe may appear after any other byte. The bench drives each byte on a falling edge and holds it through one rising edge. It then checks the outputs on the following falling edge, which is the only cycle in which the strobe for that byte can exist. The next byte is driven one idle cycle later, so every strobe that has not yet been checked has already dropped.

// File: rtl/servo_cmd_pkg.sv
package servo_cmd_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t CH_NL     = 8'h0A;
  localparam byte_t CH_ZERO   = 8'h30;
  localparam byte_t CH_NINE   = 8'h39;
  localparam byte_t CH_JOINT0 = 8'h41;
endpackage

// File: rtl/servo_cmd_classify.sv
module servo_cmd_classify
  import servo_cmd_pkg::*;
#(
  parameter int NUM_JOINTS = 3,
  parameter int JW         = 2
) (
  input  byte_t         byte_i,
  output logic          is_nl_o,
  output logic          is_digit_o,
  output logic [3:0]    digit_o,
  output logic          is_letter_o,
  output logic [JW-1:0] joint_o
);
  localparam byte_t LAST_JOINT = byte_t'(int'(CH_JOINT0) + NUM_JOINTS - 1);

  always_comb begin
    is_nl_o     = (byte_i == CH_NL);
    is_digit_o  = (byte_i >= CH_ZERO) && (byte_i <= CH_NINE);
    digit_o     = 4'(byte_i - CH_ZERO);
    is_letter_o = (byte_i >= CH_JOINT0) && (byte_i <= LAST_JOINT);
    joint_o     = JW'(byte_i - CH_JOINT0);
  end
endmodule

// File: rtl/servo_cmd_accum.sv
module servo_cmd_accum #(
  parameter int ACC_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [3:0]       digit_i,
  output logic [ACC_W-1:0] value_o
);
  logic [ACC_W+3:0] next_w;

  // decimal shift-in: value*10 + digit
  assign next_w = ({4'd0, value_o} << 3) + ({4'd0, value_o} << 1) + (ACC_W+4)'(digit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     value_o <= '0;
    else if (clr_i)  value_o <= '0;
    else if (load_i) value_o <= ACC_W'(next_w);
  end
endmodule

// File: rtl/servo_cmd_frame.sv
module servo_cmd_frame #(
  parameter int FRAME_LEN = 4,
  parameter int IW        = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic close_i,
  input  logic is_letter_i,
  input  logic is_digit_i,
  output logic letter_slot_o,
  output logic digit_slot_o,
  output logic frame_ok_o
);
  localparam logic [IW-1:0] IDX_FULL = IW'(FRAME_LEN);
  localparam logic [IW-1:0] IDX_OVER = IW'(FRAME_LEN + 1);

  logic [IW-1:0] idx_q;
  logic          bad_q;

  assign letter_slot_o = (idx_q == '0);
  assign digit_slot_o  = (idx_q != '0) && (idx_q < IDX_FULL);
  assign frame_ok_o    = (idx_q == IDX_FULL) && !bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      bad_q <= 1'b0;
    end else if (close_i) begin
      idx_q <= '0;
      bad_q <= 1'b0;
    end else if (step_i) begin
      if (idx_q != IDX_OVER) idx_q <= idx_q + 1'b1;  // saturate past a full line
      if (letter_slot_o)     bad_q <= !is_letter_i;
      else if (digit_slot_o && !is_digit_i) bad_q <= 1'b1;
    end
  end
endmodule

// File: rtl/servo_cmd_parser.sv
module servo_cmd_parser
  import servo_cmd_pkg::*;
#(
  parameter int NUM_JOINTS = 3,
  parameter int DIGITS     = 3,
  parameter int MAX_ANGLE  = 180,
  parameter int ANGLE_W    = 8,
  parameter int JW         = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               byte_valid_i,
  input  logic [7:0]         byte_i,
  output logic               cmd_valid_o,
  output logic [JW-1:0]      cmd_joint_o,
  output logic [ANGLE_W-1:0] cmd_angle_o,
  output logic               cmd_err_o
);
  localparam int FRAME_LEN = DIGITS + 1;
  localparam int IW        = $clog2(FRAME_LEN + 2);
  localparam int ACC_W     = $clog2(10 ** DIGITS);

  logic          is_nl, is_digit, is_letter;
  logic [3:0]    digit;
  logic [JW-1:0] joint_w;
  logic          step, close;
  logic          letter_slot, digit_slot, frame_ok;
  logic [ACC_W-1:0] acc;
  logic [JW-1:0] joint_q;
  logic          accept;

  servo_cmd_classify #(.NUM_JOINTS(NUM_JOINTS), .JW(JW)) u_cls (
    .byte_i     (byte_i),
    .is_nl_o    (is_nl),
    .is_digit_o (is_digit),
    .digit_o    (digit),
    .is_letter_o(is_letter),
    .joint_o    (joint_w)
  );

  assign step  = byte_valid_i && !is_nl;
  assign close = byte_valid_i && is_nl;

  servo_cmd_frame #(.FRAME_LEN(FRAME_LEN), .IW(IW)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .step_i       (step),
    .close_i      (close),
    .is_letter_i  (is_letter),
    .is_digit_i   (is_digit),
    .letter_slot_o(letter_slot),
    .digit_slot_o (digit_slot),
    .frame_ok_o   (frame_ok)
  );

  servo_cmd_accum #(.ACC_W(ACC_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (close),
    .load_i (step && digit_slot && is_digit),
    .digit_i(digit),
    .value_o(acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   joint_q <= '0;
    else if (step && letter_slot)  joint_q <= joint_w;
  end

  assign accept = close && frame_ok && (acc <= ACC_W'(MAX_ANGLE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o <= 1'b0;
      cmd_err_o   <= 1'b0;
      cmd_joint_o <= '0;
      cmd_angle_o <= '0;
    end else begin
      cmd_valid_o <= accept;
      cmd_err_o   <= close && !accept;
      if (accept) begin
        cmd_joint_o <= joint_q;
        cmd_angle_o <= ANGLE_W'(acc);
      end
    end
  end
endmodule

// File: rtl/servo_cmd_parser_chk.sv
module servo_cmd_parser_chk #(
  parameter int NUM_JOINTS = 3,
  parameter int MAX_ANGLE  = 180,
  parameter int ANGLE_W    = 8,
  parameter int JW         = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               byte_valid_i,
  input logic [7:0]         byte_i,
  input logic               cmd_valid_o,
  input logic [JW-1:0]      cmd_joint_o,
  input logic [ANGLE_W-1:0] cmd_angle_o,
  input logic               cmd_err_o
);
  p_exclusive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_o && cmd_err_o));

  p_valid_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_o |-> ($stable(cmd_angle_o) && $stable(cmd_joint_o)));

  p_angle_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (int'(cmd_angle_o) <= MAX_ANGLE));

  p_joint_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (int'(cmd_joint_o) < NUM_JOINTS));

  p_valid_after_nl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(byte_valid_i && byte_i == 8'h0A));

  p_err_after_nl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |-> $past(byte_valid_i && byte_i == 8'h0A));

  p_no_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_valid_i && byte_i == 8'h0A) |=> !(cmd_valid_o || cmd_err_o));
endmodule

bind servo_cmd_parser servo_cmd_parser_chk #(
  .NUM_JOINTS(NUM_JOINTS),
  .MAX_ANGLE (MAX_ANGLE),
  .ANGLE_W   (ANGLE_W),
  .JW        (JW)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .byte_valid_i(byte_valid_i),
  .byte_i      (byte_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_joint_o (cmd_joint_o),
  .cmd_angle_o (cmd_angle_o),
  .cmd_err_o   (cmd_err_o)
);

// File: tb/servo_cmd_parser_tb.sv
module servo_cmd_parser_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bv = 1'b0;
  logic [7:0] bd = 8'h00;
  logic       v, e;
  logic [1:0] j;
  logic [7:0] a;

  int checks = 0;
  int fails  = 0;
  int last_j = 0;
  int last_a = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  servo_cmd_parser dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .byte_valid_i(bv),
    .byte_i      (bd),
    .cmd_valid_o (v),
    .cmd_joint_o (j),
    .cmd_angle_o (a),
    .cmd_err_o   (e)
  );

  // drive at falling edge, taken at next rising edge; returns on the falling edge after it
  task automatic send_byte(input logic [7:0] b, input int gap);
    @(negedge clk);
    bd = b;
    bv = 1'b1;
    @(negedge clk);
    bv = 1'b0;
    bd = 8'hxx;
    for (int k = 0; k < gap; k++) begin
      if (v !== 1'b0 || e !== 1'b0) begin
        checks++; fails++;
        $display("FAIL R7 strobe during gap: valid=%0b err=%0b expected 0 0", v, e);
      end
      @(negedge clk);
    end
  endtask

  task automatic check_line(input bit ok, input int ej, input int ea, input string req);
    checks++;
    if (ok) begin
      if (v !== 1'b1 || e !== 1'b0 || int'(j) != ej || int'(a) != ea) begin
        fails++;
        $display("FAIL %s valid=%0b err=%0b joint=%0d angle=%0d expected valid=1 err=0 joint=%0d angle=%0d",
                 req, v, e, j, a, ej, ea);
      end
      last_j = ej;
      last_a = ea;
    end else begin
      if (v !== 1'b0 || e !== 1'b1 || int'(j) != last_j || int'(a) != last_a) begin
        fails++;
        $display("FAIL %s valid=%0b err=%0b joint=%0d angle=%0d expected valid=0 err=1 joint=%0d angle=%0d",
                 req, v, e, j, a, last_j, last_a);
      end
    end
  endtask

  task automatic send_std(input logic [7:0] c0, input logic [7:0] c1, input logic [7:0] c2,
                          input logic [7:0] c3, input int gap);
    send_byte(c0, gap);
    send_byte(c1, gap);
    send_byte(c2, gap);
    send_byte(c3, gap);
    send_byte(8'h0A, 0);
  endtask

  function automatic logic [7:0] dch(input int d);
    return 8'(8'h30 + d);
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: run incomplete, expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (v !== 1'b0 || e !== 1'b0 || j !== 2'd0 || a !== 8'd0) begin
      fails++;
      $display("FAIL R1 valid=%0b err=%0b joint=%0d angle=%0d expected 0 0 0 0", v, e, j, a);
    end

    // R2/R3: every three-digit value on every joint
    for (int jj = 0; jj < 3; jj++)
      for (int val = 0; val < 1000; val++) begin
        send_std(8'(8'h41 + jj), dch(val / 100), dch((val / 10) % 10), dch(val % 10), 0);
        check_line(val <= 180, jj, val, val <= 180 ? "R2" : "R3");
      end

    // R5: every possible first byte
    for (int b = 0; b < 256; b++) begin
      if (b == 8'h0A) continue;
      send_std(8'(b), dch(0), dch(9), dch(5), 0);
      check_line(b >= 8'h41 && b <= 8'h43, b - 8'h41, 95, "R5");
    end

    // R6: every possible byte in each digit slot
    for (int p = 0; p < 3; p++)
      for (int b = 0; b < 256; b++) begin
        logic [7:0] d [3];
        bit isd;
        int val;
        if (b == 8'h0A) continue;
        d[0] = dch(0); d[1] = dch(0); d[2] = dch(0);
        d[p] = 8'(b);
        isd = (b >= 8'h30 && b <= 8'h39);
        val = isd ? (b - 8'h30) * (p == 0 ? 100 : (p == 1 ? 10 : 1)) : 0;
        send_std(8'h42, d[0], d[1], d[2], 0);
        check_line(isd && val <= 180, 1, val, "R6");
      end

    // R4: byte counts 0..8 before the newline, then R8 resync
    for (int n = 0; n < 9; n++) begin
      for (int k = 0; k < n; k++) send_byte(k == 0 ? 8'h43 : dch(1), 0);
      send_byte(8'h0A, 0);
      check_line(n == 4, 2, 111, "R4");
      send_std(8'h41, dch(0), dch(4), dch(2), 0);
      check_line(1'b1, 0, 42, "R8");
    end

    // R8: resync after a bad letter and after a bad digit
    send_std(8'h5A, dch(0), dch(1), dch(0), 0);
    check_line(1'b0, 0, 0, "R8");
    send_std(8'h43, dch(1), dch(8), dch(0), 0);
    check_line(1'b1, 2, 180, "R8");
    send_std(8'h41, dch(1), 8'h2E, dch(0), 0);
    check_line(1'b0, 0, 0, "R8");
    send_std(8'h42, dch(0), dch(0), dch(1), 0);
    check_line(1'b1, 1, 1, "R8");

    // R7: idle gaps of varied length inside a line
    for (int g = 1; g < 12; g++) begin
      int val = (g * 17) % 181;
      send_std(8'(8'h41 + g % 3), dch(val / 100), dch((val / 10) % 10), dch(val % 10), g);
      check_line(1'b1, g % 3, val, "R7");
    end
    // R7: garbage with byte_valid low must not disturb a line
    send_byte(8'h41, 0);
    @(negedge clk); bd = 8'h0A; @(negedge clk); bd = 8'h58; @(negedge clk);
    checks++;
    if (v !== 1'b0 || e !== 1'b0) begin
      fails++;
      $display("FAIL R7 strobe on unqualified byte: valid=%0b err=%0b expected 0 0", v, e);
    end
    send_byte(dch(1), 0); send_byte(dch(2), 0); send_byte(dch(3), 0); send_byte(8'h0A, 0);
    check_line(1'b1, 0, 123, "R7");

    // R9: strobe lasts one cycle
    @(negedge clk);
    checks++;
    if (v !== 1'b0 || e !== 1'b0 || int'(a) != 123) begin
      fails++;
      $display("FAIL R9 valid=%0b err=%0b angle=%0d expected 0 0 123", v, e, a);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule